// File: doc/BRIEF.md
# Bus Status Cycle Classifier

This block observes a processor's 4-bit bus status code and its address-latch strobe. Every bus cycle opens with the strobe high, and the code is valid once the strobe has fallen. The block takes one sample of the code per cycle. It brings the strobe, the code and the active-low read strobe into the system clock domain. At each falling edge of the strobe it produces one classification, as a one-hot cycle-type vector or an unknown-code flag.

Two trackers run alongside the decoder.

- **Startup-order checker.** It re-arms at the start of every run of reset codes. It compares the cycles that follow against the fixed power-up order: 3×reset, status update, vector fetch, 2×ALU, vector fetch, workspace-pointer update, 3×workspace write, instruction fetch. It reports success, or the position of the first cycle that differs. It also counts the length of the current reset run.
- **Trap detector.** It raises a flag when a macroinstruction-detect cycle is followed by a run of internal ALU/macrostore cycles with no read strobe. This pattern shows that the CPU is stuck in an illegal-opcode loop.

Top module: `bsc_top`

## Requirements
- R1: Each falling edge of `addr_strobe` produces exactly one `cyc_valid` pulse, one clock long. The pulse is visible after the third rising clock edge that sees the strobe low. No pulse occurs while the strobe holds its level.
- R2: During a pulse, `cyc_type` has exactly one bit set for a known code. The codes map to bits as follows: 1010 reset→bit0, 1101 status update→bit1, 0101 vector fetch→bit2, 1001 ALU/macrostore→bit3, 1100 workspace-pointer update→bit4, 0110 workspace write→bit5, 0011 instruction fetch→bit6, 0010 immediate operand→bit7, 1110 macroinstruction detect→bit8.
- R3: Any of the seven codes not listed in R2 sets `cyc_unknown` with `cyc_type` all zero.
- R4: Outside a `cyc_valid` pulse, `cyc_type` and `cyc_unknown` are zero.
- R5: `reset_len` restarts at 1 on the first reset code of a run and counts each further consecutive reset code. It saturates at 2^RLEN_W−1 and holds its value when other codes arrive.
- R6: A reset run followed by the exact 13-entry startup order (positions 0–12) sets `seq_done` on the instruction-fetch cycle. `seq_err` stays low.
- R7: The first cycle that differs from the startup order sets `seq_err`, and `seq_err_idx` records that cycle's position (0–12). Both hold until a new reset run begins, which clears `seq_err` and `seq_done`.
- R8: The reset run must be exactly three cycles long. Four reset codes give error position 3, and two reset codes followed by a status update give error position 2.
- R9: `trap_flag` sets on the TRAP_RUN-th consecutive ALU/macrostore cycle after a macroinstruction-detect cycle. The count applies only if `rd_n` has not been seen low since that detect cycle. A low `rd_n` or any other code ends the run. A reset code clears the flag.
- R10: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strobe | input | 1 | Address-latch strobe, asynchronous; a fall opens a cycle's sampling |
| bus_code | input | 4 | Bus status code, stable while the strobe is low |
| rd_n | input | 1 | Active-low read strobe, asynchronous |
| cyc_valid | output | 1 | One-clock pulse per classified cycle |
| cyc_type | output | 9 | One-hot cycle type (R2 bit order) |
| cyc_unknown | output | 1 | Code outside the decode table |
| seq_done | output | 1 | Startup order completed correctly |
| seq_err | output | 1 | Startup order broken |
| seq_err_idx | output | 4 | Position of first mismatching cycle |
| reset_len | output | RLEN_W | Length of current/most recent reset run |
| trap_flag | output | 1 | Illegal-opcode trap loop detected |

## Verification
All results of one bus cycle appear together with the `cyc_valid` pulse. The type flags, the tracker states, the reset count and the trap flag all update at the third rising clock edge after the strobe is first seen low. The code is held stable over that window.

The driver records each cycle's expected results in a queue at the moment it lowers the strobe. The monitor samples on falling clock edges. It pops one entry for each pulse it sees, and on every idle falling edge it checks that the flags are zero.

The read strobe is pulsed only after the classification edge of its cycle, so its effect on the trap run is due from the next cycle onward.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int NTYPE   = 9;
  localparam int SEQ_LEN = 13;

  localparam logic [3:0] C_RST = 4'b1010;
  localparam logic [3:0] C_STU = 4'b1101;
  localparam logic [3:0] C_VEC = 4'b0101;
  localparam logic [3:0] C_ALU = 4'b1001;
  localparam logic [3:0] C_WPU = 4'b1100;
  localparam logic [3:0] C_WSW = 4'b0110;
  localparam logic [3:0] C_IAQ = 4'b0011;
  localparam logic [3:0] C_IOP = 4'b0010;
  localparam logic [3:0] C_MID = 4'b1110;

  typedef enum logic [3:0] {
    T_RST = 4'd0, T_STU = 4'd1, T_VEC = 4'd2, T_ALU = 4'd3, T_WPU = 4'd4,
    T_WSW = 4'd5, T_IAQ = 4'd6, T_IOP = 4'd7, T_MID = 4'd8
  } ctype_e;

  // Expected code at each position of the power-up order
  function automatic logic [3:0] start_code(input logic [3:0] pos);
    case (pos)
      4'd0, 4'd1, 4'd2:    start_code = C_RST;
      4'd3:                start_code = C_STU;
      4'd4, 4'd7:          start_code = C_VEC;
      4'd5, 4'd6:          start_code = C_ALU;
      4'd8:                start_code = C_WPU;
      4'd9, 4'd10, 4'd11:  start_code = C_WSW;
      4'd12:               start_code = C_IAQ;
      default:             start_code = 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/bsc_sync.sv
module bsc_sync #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  input  logic [3:0] code_in,
  input  logic       rd_n,
  output logic       evt,
  output logic [3:0] code,
  output logic       rd_low
);
  logic [SYNC:0]   stb_sh;
  logic [SYNC-1:0] rd_sh;
  logic [3:0]      code_sh [SYNC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_sh <= '0;
      rd_sh  <= '1;
    end else begin
      stb_sh <= {stb_sh[SYNC-1:0], strobe};
      rd_sh  <= {rd_sh[SYNC-2:0], rd_n};
    end
  end

  generate
    for (genvar i = 0; i < SYNC; i++) begin : g_code
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_sh[i] <= '0;
        else if (i == 0) code_sh[i] <= code_in;
        else code_sh[i] <= code_sh[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign evt    = stb_sh[SYNC] & ~stb_sh[SYNC-1];
  assign code   = code_sh[SYNC-1];
  assign rd_low = ~rd_sh[SYNC-1];

  AST_SINGLE_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt); // R1
endmodule

// File: rtl/bsc_decode.sv
module bsc_decode
  import bsc_pkg::*;
(
  input  logic [3:0]       code,
  output logic [NTYPE-1:0] oh,
  output logic             unknown
);
  always_comb begin
    oh      = '0;
    unknown = 1'b0;
    case (code)
      C_RST:   oh[T_RST] = 1'b1;
      C_STU:   oh[T_STU] = 1'b1;
      C_VEC:   oh[T_VEC] = 1'b1;
      C_ALU:   oh[T_ALU] = 1'b1;
      C_WPU:   oh[T_WPU] = 1'b1;
      C_WSW:   oh[T_WSW] = 1'b1;
      C_IAQ:   oh[T_IAQ] = 1'b1;
      C_IOP:   oh[T_IOP] = 1'b1;
      C_MID:   oh[T_MID] = 1'b1;
      default: unknown   = 1'b1;
    endcase
  end
endmodule

// File: rtl/bsc_seq.sv
module bsc_seq
  import bsc_pkg::*;
#(
  parameter int RLEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [3:0]        code,
  output logic              done,
  output logic              err,
  output logic [3:0]        err_idx,
  output logic [RLEN_W-1:0] rlen
);
  localparam logic [3:0]        LAST = 4'(SEQ_LEN - 1);
  localparam logic [RLEN_W-1:0] RMAX = {RLEN_W{1'b1}};

  logic              act_q, act_d, prst_q, prst_d;
  logic              err_q, err_d, done_q, done_d;
  logic [3:0]        idx_q, idx_d, eidx_q, eidx_d, idx_use;
  logic [RLEN_W-1:0] rlen_q, rlen_d;
  logic              is_rst;

  assign is_rst = (code == C_RST);

  always_comb begin
    act_d   = act_q;
    prst_d  = prst_q;
    err_d   = err_q;
    done_d  = done_q;
    idx_d   = idx_q;
    eidx_d  = eidx_q;
    rlen_d  = rlen_q;
    idx_use = idx_q;
    if (evt) begin
      if (is_rst && !prst_q) begin
        act_d   = 1'b1;
        idx_use = '0;
        err_d   = 1'b0;
        eidx_d  = '0;
        done_d  = 1'b0;
        rlen_d  = '0;
      end
      if (is_rst && rlen_d != RMAX) rlen_d = rlen_d + 1'b1;
      if (act_d && !err_d && !done_d) begin
        if (code != start_code(idx_use)) begin
          err_d  = 1'b1;
          eidx_d = idx_use;
        end else if (idx_use == LAST) begin
          done_d = 1'b1;
        end
        idx_d = idx_use + 4'd1;
      end
      prst_d = is_rst;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      prst_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      eidx_q <= '0;
      rlen_q <= '0;
    end else if (evt) begin
      act_q  <= act_d;
      prst_q <= prst_d;
      err_q  <= err_d;
      done_q <= done_d;
      idx_q  <= idx_d;
      eidx_q <= eidx_d;
      rlen_q <= rlen_d;
    end
  end

  assign done    = done_q;
  assign err     = err_q;
  assign err_idx = eidx_q;
  assign rlen    = rlen_q;

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(evt && is_rst)) |=> err_q); // R7
  AST_DONE_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && err_q)); // R6
  AST_RLEN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && is_rst && !prst_q) |=> (rlen_q == RLEN_W'(1))); // R5
endmodule

// File: rtl/bsc_trap.sv
module bsc_trap
  import bsc_pkg::*;
#(
  parameter int TRAP_RUN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt,
  input  logic [3:0] code,
  input  logic       rd_low,
  output logic       trap
);
  localparam int RW = $clog2(TRAP_RUN + 1);
  localparam logic [RW-1:0] RUN_MAX  = RW'(TRAP_RUN);
  localparam logic [RW-1:0] RUN_LAST = RW'(TRAP_RUN - 1);

  logic          arm_q, arm_d, trap_q, trap_d;
  logic [RW-1:0] run_q, run_d;
  logic          upd;

  assign upd = evt | (rd_low & arm_q);

  always_comb begin
    arm_d  = arm_q;
    run_d  = run_q;
    trap_d = trap_q;
    if (evt) begin
      if (code == C_RST) begin
        arm_d  = 1'b0;
        run_d  = '0;
        trap_d = 1'b0;
      end else if (code == C_MID) begin
        arm_d = 1'b1;
        run_d = '0;
      end else if (arm_q && code == C_ALU) begin
        if (run_q != RUN_MAX) run_d = run_q + 1'b1;
        if (run_q == RUN_LAST) trap_d = 1'b1;
      end else begin
        arm_d = 1'b0;
        run_d = '0;
      end
    end else if (rd_low && arm_q) begin
      arm_d = 1'b0;
      run_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      run_q  <= '0;
      trap_q <= 1'b0;
    end else if (upd) begin
      arm_q  <= arm_d;
      run_q  <= run_d;
      trap_q <= trap_d;
    end
  end

  assign trap = trap_q;

  AST_TRAP_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_q) |-> $past(evt)); // R9
  AST_TRAP_CLR_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && code == C_RST) |=> !trap_q); // R9
endmodule

// File: rtl/bsc_top.sv
module bsc_top
  import bsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RLEN_W      = 8,
  parameter int TRAP_RUN    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_strobe,
  input  logic [3:0]        bus_code,
  input  logic              rd_n,
  output logic              cyc_valid,
  output logic [8:0]        cyc_type,
  output logic              cyc_unknown,
  output logic              seq_done,
  output logic              seq_err,
  output logic [3:0]        seq_err_idx,
  output logic [RLEN_W-1:0] reset_len,
  output logic              trap_flag
);
  logic             evt, rd_low, unk_c;
  logic [3:0]       code;
  logic [NTYPE-1:0] oh_c;

  bsc_sync #(.SYNC(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe(addr_strobe), .code_in(bus_code),
    .rd_n(rd_n), .evt(evt), .code(code), .rd_low(rd_low)
  );

  bsc_decode u_dec (.code(code), .oh(oh_c), .unknown(unk_c));

  bsc_seq #(.RLEN_W(RLEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .evt(evt), .code(code),
    .done(seq_done), .err(seq_err), .err_idx(seq_err_idx), .rlen(reset_len)
  );

  bsc_trap #(.TRAP_RUN(TRAP_RUN)) u_trap (
    .clk(clk), .rst_n(rst_n), .evt(evt), .code(code), .rd_low(rd_low),
    .trap(trap_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_valid   <= 1'b0;
      cyc_type    <= '0;
      cyc_unknown <= 1'b0;
    end else begin
      cyc_valid   <= evt;
      cyc_type    <= evt ? oh_c : '0;
      cyc_unknown <= evt & unk_c;
    end
  end

  AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |-> (cyc_type == '0 && !cyc_unknown)); // R4
  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> ($countones({cyc_type, cyc_unknown}) == 1)); // R2
  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |=> !cyc_valid); // R1
endmodule

// File: tb/tb_bsc_top.sv
module tb_bsc_top;
  localparam logic [3:0] RST = 4'b1010, STU = 4'b1101, VEC = 4'b0101,
    ALU = 4'b1001, WPU = 4'b1100, WSW = 4'b0110, IAQ = 4'b0011,
    IOP = 4'b0010, MID = 4'b1110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_strobe = 1'b1;
  logic [3:0] bus_code = 4'b0000;
  logic rd_n = 1'b1;
  logic cyc_valid, cyc_unknown, seq_done, seq_err, trap_flag;
  logic [8:0] cyc_type;
  logic [3:0] seq_err_idx;
  logic [7:0] reset_len;

  bsc_top dut (
    .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .bus_code(bus_code),
    .rd_n(rd_n), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
    .cyc_unknown(cyc_unknown), .seq_done(seq_done), .seq_err(seq_err),
    .seq_err_idx(seq_err_idx), .reset_len(reset_len), .trap_flag(trap_flag)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic [8:0] oh; logic unk; logic done; logic err;
    logic [3:0] eidx; logic [7:0] rlen; logic trap;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0, n_cyc = 0, n_pulse = 0;
  bit running = 0, finished = 0;

  // reference state, built from the requirements
  bit m_act = 0, m_prst = 0, m_err = 0, m_done = 0, m_arm = 0, m_trap = 0;
  int m_idx = 0, m_eidx = 0, m_rlen = 0, m_run = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] order_at(input int p);
    case (p)
      0, 1, 2: return RST;
      3: return STU;
      4, 7: return VEC;
      5, 6: return ALU;
      8: return WPU;
      9, 10, 11: return WSW;
      12: return IAQ;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [8:0] onehot_of(input logic [3:0] c);
    case (c)
      RST: return 9'h001; STU: return 9'h002; VEC: return 9'h004;
      ALU: return 9'h008; WPU: return 9'h010; WSW: return 9'h020;
      IAQ: return 9'h040; IOP: return 9'h080; MID: return 9'h100;
      default: return 9'h000;
    endcase
  endfunction

  task automatic model(input logic [3:0] c, output exp_t e);
    if (c == RST && !m_prst) begin
      m_act = 1; m_idx = 0; m_err = 0; m_eidx = 0; m_done = 0; m_rlen = 0;
    end
    if (c == RST && m_rlen < 255) m_rlen++;
    if (m_act && !m_err && !m_done) begin
      if (c != order_at(m_idx)) begin m_err = 1; m_eidx = m_idx; end
      else if (m_idx == 12) m_done = 1;
      m_idx++;
    end
    m_prst = (c == RST);
    if (c == RST) begin m_arm = 0; m_run = 0; m_trap = 0; end
    else if (c == MID) begin m_arm = 1; m_run = 0; end
    else if (m_arm && c == ALU) begin
      if (m_run < 4) m_run++;
      if (m_run == 4) m_trap = 1;
    end else begin m_arm = 0; m_run = 0; end
    e.oh = onehot_of(c); e.unk = (onehot_of(c) == 0);
    e.done = m_done; e.err = m_err; e.eidx = 4'(m_eidx);
    e.rlen = 8'(m_rlen); e.trap = m_trap;
  endtask

  task automatic bus(input logic [3:0] c, input bit rdl = 0);
    exp_t e;
    @(negedge clk); addr_strobe = 1'b1; bus_code = c;
    repeat (2) @(negedge clk);
    addr_strobe = 1'b0;
    model(c, e);
    q.push_back(e);
    n_cyc++;
    repeat (2) @(negedge clk);
    if (rdl) begin
      rd_n = 1'b0;
      if (m_arm) begin m_arm = 0; m_run = 0; end
    end
    repeat (2) @(negedge clk);
    rd_n = 1'b1;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (running) begin
      if (cyc_valid) begin
        n_pulse++;
        if (q.size() == 0) chk("R1 unexpected pulse", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk("R2 type", cyc_type, e.oh);
          chk("R3 unknown", cyc_unknown, e.unk);
          chk("R6 done", seq_done, e.done);
          chk("R7 err", seq_err, e.err);
          chk("R7 err_idx", seq_err_idx, e.eidx);
          chk("R5 reset_len", reset_len, e.rlen);
          chk("R9 trap", trap_flag, e.trap);
        end
      end else begin
        chk("R4 idle flags", {cyc_type, cyc_unknown}, 10'h000);
      end
    end
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finish");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: outputs in reset
    chk("R10 reset outputs",
        {cyc_valid, cyc_type, cyc_unknown, seq_done, seq_err, seq_err_idx, reset_len, trap_flag},
        '0);
    rst_n = 1'b1;
    running = 1;
    // R6: correct power-up order
    repeat (3) bus(RST);
    bus(STU); bus(VEC); bus(ALU); bus(ALU); bus(VEC); bus(WPU);
    repeat (3) bus(WSW);
    bus(IAQ);
    // R2 remaining codes; R9 trap after detect
    bus(IOP); bus(MID);
    repeat (4) bus(ALU);
    // R3 unknown codes
    bus(4'b0000); bus(4'b1111); bus(4'b0111);
    // R8: four resets -> position 3
    repeat (4) bus(RST);
    bus(STU);
    repeat (4) @(negedge clk);
    chk("R8 four resets idx", seq_err_idx, 4'd3);
    bus(ALU); bus(IAQ);              // R7 sticky
    // R8: two resets -> position 2
    repeat (2) bus(RST);
    bus(STU);
    repeat (4) @(negedge clk);
    chk("R8 two resets idx", seq_err_idx, 4'd2);
    // R7: mismatch at position 6
    repeat (3) bus(RST);
    bus(STU); bus(VEC); bus(ALU); bus(WPU); bus(ALU);
    // R9: read strobe breaks the run
    bus(MID); bus(ALU, 1); bus(ALU); bus(ALU); bus(ALU); bus(ALU);
    // R9: full run, then cleared by reset
    bus(MID);
    repeat (4) bus(ALU);
    bus(RST);
    // R5: saturation
    repeat (259) bus(RST);
    repeat (6) @(negedge clk);
    chk("R5 saturated", reset_len, 8'd255);
    chk("R1 pulse count", n_pulse, n_cyc);
    chk("R1 queue drained", q.size(), 0);
    finished = 1;
    summary();
  end
endmodule